// File: doc/BRIEF.md
# Multi-Word Command Register Sequencer

This block is the host-facing command front end of a storage adapter. Software writes an operation code into a command register and then streams that operation's arguments, one 32-bit word at a time, into a command data register. The sequencer collects the words in a small buffer. As soon as the selected operation has all the argument bytes it needs, the sequencer emits a single-cycle execute strobe carrying the opcode and the collected words. In the same clock edge it latches the operation's result into a readable status register and falls back to its idle default operation.

Operations that take no arguments run on the command write itself. A code outside the legal range selects a default operation that takes no arguments and always reports failure. Several operations report a fixed outcome. Two operations report the value on an external result input, which is driven by the handler logic outside this block. Message-queue setup reports that value only while message support is enabled, and fails otherwise. The register bus is 32 bits wide and takes aligned 4-byte accesses only.

Top module: `cmdseq_top`

## Requirements
- R1: After reset, the status reads 0 (success), the current operation is the default (code 0) and the word count is zero, so a data write fires the default operation.
- R2: A command code counts as valid only when 0 < code < 10. Any other 32-bit value, including 0, 10 and 0xFFFFFFFF, selects the default operation 0, which needs no words.
- R3: A command write clears the word count and sets the status to 0xFFFFFFFE (more data needed). If the new operation needs no words, it executes on that same write. A command write in the middle of a sequence abandons the earlier one.
- R4: A data write stores the word at index count, where word i of exec_data sits at bits [32*i+31:32*i], and then increments the count. Execution happens on the write that makes count*4 at least the operation's byte requirement. The count never reaches the buffer depth.
- R5: Default payloads in words: queue setup (2) 8, abort (3) 2, configuration (4) 6, target reset (5) 3, message setup (7) 4. All other operations (0, 1, 6, 8, 9) need 0 words.
- R6: On execution, exec_valid is high for that write cycle only and exec_op carries the operation. At the same edge the status takes the result, and the operation and count return to default and zero.
- R7: Operations 0, 4, 8 and 9 give status 0xFFFFFFFF. Bus reset (1), abort (3) and adapter reset (6) give 0. Queue setup (2) and target reset (5) give exec_result.
- R8: Message setup (7) gives 0xFFFFFFFF when msg_en is 0 and exec_result when msg_en is 1.
- R9: Offset 0x00 takes command writes and offset 0x04 takes data writes. Offset 0x08 returns the status on reads. Reads at any other offset return 0. Writes to any other offset, including 0x08 and unaligned addresses, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| msg_en | input | 1 | Message support enabled |
| exec_result | input | 32 | Result from the external handler |
| exec_valid | output | 1 | Execute strobe |
| exec_op | output | 4 | Operation being executed |
| exec_data | output | DEPTH*32 | Collected argument words |

## Verification
The bench builds the block with its default payload parameters. This makes the buffer eight words deep, so the longest operation fills every word slot and the bypass of the last word into exec_data is exercised at the top index. The same build gives operations with 2, 3, 4 and 6 words, so each compare threshold fires at a distinct count. Together these cover both the word-count limits and the immediate execution of zero-length operations.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NONE          = 4'd0,
      OP_BUS_RESET     = 4'd1,
      OP_QUEUE_SETUP   = 4'd2,
      OP_ABORT         = 4'd3,
      OP_CONFIG        = 4'd4,
      OP_TGT_RESET     = 4'd5,
      OP_ADAPTER_RESET = 4'd6,
      OP_MSG_SETUP     = 4'd7,
      OP_ISSUE         = 4'd8,
      OP_UNPLUG        = 4'd9
   } op_e;

   // first code past the legal range
   localparam logic [31:0] OP_LIMIT = 32'd10;

   typedef enum logic [1:0] {
      RC_FAIL,
      RC_OK,
      RC_EXT,
      RC_MSG
   } rclass_e;

   localparam logic [31:0] ST_OK   = 32'h0000_0000;
   localparam logic [31:0] ST_FAIL = 32'hFFFF_FFFF;
   localparam logic [31:0] ST_MORE = 32'hFFFF_FFFE;

   localparam logic [31:0] OFS_CMD    = 32'h00;
   localparam logic [31:0] OFS_DATA   = 32'h04;
   localparam logic [31:0] OFS_STATUS = 32'h08;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
   import cmdseq_pkg::*;
(
   input  logic [31:0] code,
   output op_e         op
);
   logic legal;

   assign legal = (code != 32'd0) && (code < OP_LIMIT);
   assign op    = legal ? op_e'(code[OP_W-1:0]) : OP_NONE;

endmodule

// File: rtl/cmdseq_opinfo.sv
module cmdseq_opinfo
   import cmdseq_pkg::*;
#(
   parameter int QSETUP_WORDS = 8,
   parameter int ABORT_WORDS  = 2,
   parameter int CONFIG_WORDS = 6,
   parameter int TRESET_WORDS = 3,
   parameter int MSETUP_WORDS = 4,
   parameter int CNT_W        = 4
) (
   input  op_e              op,
   output logic [CNT_W-1:0] need,
   output rclass_e          rclass
);
   always_comb begin
      case (op)
         OP_QUEUE_SETUP: need = CNT_W'(QSETUP_WORDS);
         OP_ABORT:       need = CNT_W'(ABORT_WORDS);
         OP_CONFIG:      need = CNT_W'(CONFIG_WORDS);
         OP_TGT_RESET:   need = CNT_W'(TRESET_WORDS);
         OP_MSG_SETUP:   need = CNT_W'(MSETUP_WORDS);
         default:        need = '0;
      endcase
   end

   always_comb begin
      case (op)
         OP_BUS_RESET, OP_ABORT, OP_ADAPTER_RESET: rclass = RC_OK;
         OP_QUEUE_SETUP, OP_TGT_RESET:             rclass = RC_EXT;
         OP_MSG_SETUP:                             rclass = RC_MSG;
         default:                                  rclass = RC_FAIL;
      endcase
   end

endmodule

// File: rtl/cmdseq_wordbuf.sv
module cmdseq_wordbuf #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [CNT_W-1:0]   idx,
   input  logic [31:0]        wdata,
   output logic [DEPTH*32-1:0] view
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [31:0] word_q;
      logic        hit;

      assign hit = we && (idx == CNT_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n)   word_q <= '0;
         else if (hit) word_q <= wdata;
      end

      // the word arriving this cycle is visible at once
      assign view[i*32 +: 32] = hit ? wdata : word_q;
   end

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
   import cmdseq_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int QSETUP_WORDS = 8,
   parameter int ABORT_WORDS  = 2,
   parameter int CONFIG_WORDS = 6,
   parameter int TRESET_WORDS = 3,
   parameter int MSETUP_WORDS = 4,
   localparam int DEPTH = max2(max2(max2(QSETUP_WORDS, ABORT_WORDS),
                                    max2(CONFIG_WORDS, TRESET_WORDS)),
                               max2(MSETUP_WORDS, 1)),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [31:0]         wdata,
   output logic [31:0]         rdata,
   input  logic                msg_en,
   input  logic [31:0]         exec_result,
   output logic                exec_valid,
   output logic [OP_W-1:0]     exec_op,
   output logic [DEPTH*32-1:0] exec_data
);
   if (ADDR_W < 4) begin : g_bad_addr
      $error("cmdseq_top: ADDR_W must be at least 4");
   end
   if (QSETUP_WORDS < 0 || ABORT_WORDS < 0 || CONFIG_WORDS < 0 ||
       TRESET_WORDS < 0 || MSETUP_WORDS < 0) begin : g_bad_len
      $error("cmdseq_top: payload lengths must be non-negative");
   end

   op_e              op_q, new_op, op_sel;
   logic [CNT_W-1:0] cnt_q, cnt_sel, need;
   logic [31:0]      status_q, result;
   rclass_e          rclass;
   logic             wr_cmd, wr_dat, accepted, fire;

   assign wr_cmd   = wr_en && (addr == OFS_CMD[ADDR_W-1:0]);
   assign wr_dat   = wr_en && (addr == OFS_DATA[ADDR_W-1:0]);
   assign accepted = wr_dat && (cnt_q < CNT_W'(DEPTH));

   cmdseq_decode u_dec (
      .code (wdata),
      .op   (new_op)
   );

   assign op_sel  = wr_cmd ? new_op : op_q;
   assign cnt_sel = wr_cmd   ? '0 :
                    accepted ? cnt_q + 1'b1 : cnt_q;

   cmdseq_opinfo #(
      .QSETUP_WORDS (QSETUP_WORDS),
      .ABORT_WORDS  (ABORT_WORDS),
      .CONFIG_WORDS (CONFIG_WORDS),
      .TRESET_WORDS (TRESET_WORDS),
      .MSETUP_WORDS (MSETUP_WORDS),
      .CNT_W        (CNT_W)
   ) u_info (
      .op     (op_sel),
      .need   (need),
      .rclass (rclass)
   );

   cmdseq_wordbuf #(
      .DEPTH (DEPTH),
      .CNT_W (CNT_W)
   ) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (accepted),
      .idx   (cnt_q),
      .wdata (wdata),
      .view  (exec_data)
   );

   // bytes arrived (count*4) against bytes required (need*4)
   assign fire = (wr_cmd || accepted) &&
                 ({cnt_sel, 2'b00} >= {need, 2'b00});

   always_comb begin
      case (rclass)
         RC_OK:   result = ST_OK;
         RC_EXT:  result = exec_result;
         RC_MSG:  result = msg_en ? exec_result : ST_FAIL;
         default: result = ST_FAIL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q     <= OP_NONE;
         cnt_q    <= '0;
         status_q <= ST_OK;
      end else if (fire) begin
         op_q     <= OP_NONE;
         cnt_q    <= '0;
         status_q <= result;
      end else if (wr_cmd) begin
         op_q     <= new_op;
         cnt_q    <= '0;
         status_q <= ST_MORE;
      end else if (accepted) begin
         cnt_q    <= cnt_sel;
      end
   end

   assign exec_valid = fire;
   assign exec_op    = op_sel;
   assign rdata      = (rd_en && (addr == OFS_STATUS[ADDR_W-1:0])) ?
                       status_q : 32'h0;

endmodule

// File: rtl/cmdseq_chk.sv
module cmdseq_chk
   import cmdseq_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic [31:0]       rdata,
   input logic              msg_en,
   input logic              exec_valid,
   input logic [OP_W-1:0]   exec_op,
   input logic [31:0]       status_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [OP_W-1:0]   op_q
);
   logic is_cmd, is_dat;
   assign is_cmd = wr_en && (addr == OFS_CMD[ADDR_W-1:0]);
   assign is_dat = wr_en && (addr == OFS_DATA[ADDR_W-1:0]);

   AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmd && (wdata == 32'd0 || wdata >= OP_LIMIT)) |-> (exec_valid && exec_op == 4'd0)); // R2
   AST_CMD_MORE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmd && !exec_valid) |=> (status_q == ST_MORE && cnt_q == '0)); // R3
   AST_DATA_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dat && !exec_valid) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(DEPTH)); // R4
   AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid |=> (cnt_q == '0 && op_q == 4'd0)); // R6
   AST_CONFIG_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && exec_op == 4'd4) |=> (status_q == ST_FAIL)); // R7
   AST_MSG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && exec_op == 4'd7 && !msg_en) |=> (status_q == ST_FAIL)); // R8
   AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr != OFS_STATUS[ADDR_W-1:0]) |-> (rdata == 32'h0)); // R9

endmodule

bind cmdseq_top cmdseq_chk #(
   .ADDR_W (ADDR_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .addr       (addr),
   .wdata      (wdata),
   .rdata      (rdata),
   .msg_en     (msg_en),
   .exec_valid (exec_valid),
   .exec_op    (exec_op),
   .status_q   (status_q),
   .cnt_q      (cnt_q),
   .op_q       (op_q)
);

// File: tb/tb_cmdseq_top.sv
module tb_cmdseq_top;
   localparam int DEPTH = 8;
   localparam logic [7:0]  AC = 8'h00, AD = 8'h04, AS = 8'h08;
   localparam logic [31:0] OK = 32'h0, FL = 32'hFFFF_FFFF, MR = 32'hFFFF_FFFE;
   localparam logic [31:0] RES = 32'h0000_5A5A;

   typedef struct packed {
      logic [7:0]  addr;
      logic [31:0] wdata;
      logic        msg;
      logic        fire;
      logic [3:0]  op;
      logic        chk0;
      logic [31:0] w0;
      logic [31:0] st;
   } vec_t;

   localparam int NV = 44;
   localparam vec_t VECS [NV] = '{
      // R5 R7: target reset, 3 words, external result
      '{AC, 32'd5,  1'b1, 1'b0, 4'd0, 1'b0, 32'd0,  MR},
      '{AD, 32'd11, 1'b1, 1'b0, 4'd0, 1'b0, 32'd0,  MR},
      '{AD, 32'd22, 1'b1, 1'b0, 4'd0, 1'b0, 32'd0,  MR},
      '{AD, 32'd33, 1'b1, 1'b1, 4'd5, 1'b1, 32'd11, RES},
      // R3 R7: zero-length operations fire on the command write
      '{AC, 32'd1,  1'b1, 1'b1, 4'd1, 1'b0, 32'd0,  OK},
      '{AC, 32'd6,  1'b1, 1'b1, 4'd6, 1'b0, 32'd0,  OK},
      // R2: out-of-range codes select the default
      '{AC, 32'd0,  1'b1, 1'b1, 4'd0, 1'b0, 32'd0,  FL},
      '{AC, 32'd10, 1'b1, 1'b1, 4'd0, 1'b0, 32'd0,  FL},
      '{AC, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'd0, 1'b0, 32'd0, FL},
      // R7: fixed failures
      '{AC, 32'd8,  1'b1, 1'b1, 4'd8, 1'b0, 32'd0,  FL},
      '{AC, 32'd9,  1'b1, 1'b1, 4'd9, 1'b0, 32'd0,  FL},
      // R6: data write while idle fires the default
      '{AD, 32'h77, 1'b1, 1'b1, 4'd0, 1'b1, 32'h77, FL},
      // R5 R7: configuration, 6 words, then fails
      '{AC, 32'd4,   1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'd101, 1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'd102, 1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'd103, 1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'd104, 1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'd105, 1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'd106, 1'b1, 1'b1, 4'd4, 1'b1, 32'd101, FL},
      // R5 R7: abort, 2 words, success
      '{AC, 32'd3,   1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hA1,  1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hA2,  1'b1, 1'b1, 4'd3, 1'b1, 32'hA1,  OK},
      // R8: message setup enabled
      '{AC, 32'd7,   1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hB1,  1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hB2,  1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hB3,  1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hB4,  1'b1, 1'b1, 4'd7, 1'b1, 32'hB1,  RES},
      // R8: message setup disabled
      '{AC, 32'd7,   1'b0, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hC1,  1'b0, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hC2,  1'b0, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hC3,  1'b0, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hC4,  1'b0, 1'b1, 4'd7, 1'b1, 32'hC1,  FL},
      // R9: writes elsewhere do not disturb an open sequence
      '{AC, 32'd5,   1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hE1,  1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{8'h0C, 32'd5, 1'b1, 1'b0, 4'd0, 1'b0, 32'd0,  MR},
      '{AS, 32'd0,   1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{8'h05, 32'd1, 1'b1, 1'b0, 4'd0, 1'b0, 32'd0,  MR},
      '{AD, 32'hE2,  1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hE3,  1'b1, 1'b1, 4'd5, 1'b1, 32'hE1,  RES},
      // R3: a new command abandons the open sequence
      '{AC, 32'd5,   1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hF1,  1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AC, 32'd3,   1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hF2,  1'b1, 1'b0, 4'd0, 1'b0, 32'd0,   MR},
      '{AD, 32'hF3,  1'b1, 1'b1, 4'd3, 1'b1, 32'hF2,  OK}
   };

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, msg_en = 1'b1;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0, rdata, exec_result = RES;
   logic        exec_valid;
   logic [3:0]  exec_op;
   logic [DEPTH*32-1:0] exec_data;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cmdseq_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .msg_en(msg_en), .exec_result(exec_result),
      .exec_valid(exec_valid), .exec_op(exec_op), .exec_data(exec_data)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive a write at the falling edge; return fire/op seen before the rising edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d,
                     output logic f, output logic [3:0] o);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
      #2;
      f = exec_valid; o = exec_op;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   initial begin
      logic f;
      logic [3:0] o;
      logic [31:0] r;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      rd(AS, r);
      check(r == OK, "R1 status after reset", r, OK);
      check(exec_valid == 1'b0, "R1 no strobe when idle", {31'd0, exec_valid}, 32'd0);
      // R9: reads of non-status offsets
      rd(AC, r);
      check(r == 32'd0, "R9 read command offset", r, 32'd0);
      rd(8'h0C, r);
      check(r == 32'd0, "R9 read unmapped offset", r, 32'd0);

      for (int i = 0; i < NV; i++) begin
         msg_en = VECS[i].msg;
         @(negedge clk);
         addr = VECS[i].addr; wdata = VECS[i].wdata; wr_en = 1'b1;
         #2;
         if (VECS[i].fire)
            check(exec_valid && exec_op == VECS[i].op &&
                  (!VECS[i].chk0 || exec_data[31:0] == VECS[i].w0),
                  $sformatf("R6 strobe row %0d", i),
                  {exec_valid, 3'd0, exec_op, exec_data[23:0]},
                  {1'b1, 3'd0, VECS[i].op, VECS[i].w0[23:0]});
         else
            check(!exec_valid, $sformatf("R4 no strobe row %0d", i),
                  {31'd0, exec_valid}, 32'd0);
         @(posedge clk);
         #1 wr_en = 1'b0;
         rd(AS, r);
         check(r == VECS[i].st, $sformatf("R7 status row %0d", i), r, VECS[i].st);
      end

      // R4 R5: queue setup fills the whole buffer
      msg_en = 1'b1;
      wr(AC, 32'd2, f, o);
      for (int k = 0; k < DEPTH - 1; k++) begin
         wr(AD, 32'h1000 + 32'(k), f, o);
         if (k == DEPTH - 2)
            check(!f, "R5 no strobe at 7 words", {31'd0, f}, 32'd0);
      end
      @(negedge clk);
      addr = AD; wdata = 32'h1007; wr_en = 1'b1;
      #2;
      check(exec_valid && exec_op == 4'd2, "R5 strobe at 8 words",
            {27'd0, exec_valid, exec_op}, {27'd0, 1'b1, 4'd2});
      for (int k = 0; k < DEPTH; k++)
         check(exec_data[k*32 +: 32] == 32'h1000 + 32'(k),
               $sformatf("R4 word %0d position", k),
               exec_data[k*32 +: 32], 32'h1000 + 32'(k));
      @(posedge clk);
      #1 wr_en = 1'b0;
      rd(AS, r);
      check(r == RES, "R7 queue setup result", r, RES);

      // R1: reset in the middle of a sequence
      wr(AC, 32'd5, f, o);
      wr(AD, 32'h55, f, o);
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk);
      #1 rst_n = 1'b1;
      rd(AS, r);
      check(r == OK, "R1 status after mid reset", r, OK);
      wr(AD, 32'h66, f, o);
      check(f && o == 4'd0, "R1 default after reset", {27'd0, f, o}, {27'd0, 1'b1, 4'd0});
      rd(AS, r);
      check(r == FL, "R1 default fails", r, FL);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule